// File: doc/BRIEF.md
# Boot-Window Flash Security Controller

This block guards the on-chip program flash against two requesters, the host processor and a debug port. After every processor reset it counts processor cycles. For the first 32 of them it opens a short boot window. During that window the debug port is shut out completely. Only a register write made during that window can set a security lock.

Once the lock is set, it stays set until the next reset. While it is set, the debug port can issue only a bulk (whole-array) erase. Page zero, where the boot code lives, can no longer be page-erased or written by either requester. A separate debug-control bit can also cut the debug clock enable and shut the debug port out.

Each request is judged in the same cycle it arrives. A granted request goes straight to the single flash command port. A blocked request produces a reject pulse and never reaches the flash. A forwarded bulk erase also asserts a clear of the coprocessor program RAM.

Top module: `flash_guard`

## Requirements
- R1: After reset, `sts_sec[7]` reads 1 until 32 cycles with `cyc_en` high have passed, and 0 from then until the next reset. While it reads 1, every debug request is rejected.
- R2: After reset, `sts_sec` reads 8'h80: the lock bit `sts_sec[6]` is 0 and all other bits other than bit 7 are 0. `dbg_clk_en` reads 1.
- R3: A write to address 8'hB2 with `reg_wr_data[6]`=1, in a cycle where `sts_sec[7]`=1, sets the lock from the next cycle. This includes the cycle of the 32nd strobe. A write with `reg_wr_data[6]`=0 leaves the lock unchanged.
- R4: A set lock is never cleared by a register write. Only reset returns it to 0.
- R5: A write that tries to set the lock while `sts_sec[7]`=0 is ignored.
- R6: While locked, a debug request is granted only for op 3 (bulk erase). Op 0 (read), op 1 (write) and op 2 (page erase) from the debug port are rejected.
- R7: While locked, op 2 (page erase) to page 0 is rejected from either requester. Page erase to any other page is still granted to the processor.
- R8: While locked, op 1 (write) to page 0 is rejected from either requester. Writes to other pages, and processor reads of page 0, are still granted.
- R9: Whenever a bulk erase (op 3) is forwarded, `pram_clr` is 1 in that cycle, whether or not the lock is set.
- R10: Writing 1 to bit 0 of address 8'hC4 drives `dbg_clk_en` to 0 and makes every debug request be rejected. Writing 0 there restores both.
- R11: A request is answered in its own cycle with exactly one of grant or reject. Only a granted request drives `fl_req`. The forwarded `fl_op` and `fl_page` equal the request, and `fl_src` is 1 for debug and 0 for the processor.
- R12: When both requesters would be granted in the same cycle, the processor is forwarded and the debug request is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low processor reset |
| cyc_en | input | 1 | Processor cycle-valid strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| cpu_req | input | 1 | Processor flash request |
| cpu_op | input | 2 | Processor op: 0 read, 1 write, 2 page erase, 3 bulk erase |
| cpu_page | input | PAGE_W | Processor target page |
| dbg_req | input | 1 | Debug flash request |
| dbg_op | input | 2 | Debug op, same encoding |
| dbg_page | input | PAGE_W | Debug target page |
| cpu_grant | output | 1 | Processor request forwarded |
| cpu_reject | output | 1 | Processor request blocked |
| dbg_grant | output | 1 | Debug request forwarded |
| dbg_reject | output | 1 | Debug request blocked |
| fl_req | output | 1 | Command to flash interface |
| fl_op | output | 2 | Forwarded op |
| fl_page | output | PAGE_W | Forwarded page |
| fl_src | output | 1 | 1 when the command is from debug |
| pram_clr | output | 1 | Coprocessor program RAM clear |
| sts_sec | output | 8 | Status: bit 7 boot window, bit 6 lock |
| dbg_clk_en | output | 1 | Debug clock enable |

## Verification
The lock-set write and the close of the boot window can fall in the same cycle. The bench provokes this by making the lock write in the cycle that carries the 32nd `cyc_en` strobe. It expects the lock to be set and the window flag to drop at the same edge. A second collision is a processor grant and a debug grant in one cycle. The bench drives both together and checks that the processor is forwarded, that `fl_src` is 0, and that the debug side rejects.

// File: rtl/flash_guard_pkg.sv
// Shared types for the flash security controller.
// Assumes a two-bit flash op code used by both requesters.
package flash_guard_pkg;
    typedef enum logic [1:0] {
        FOP_READ   = 2'd0,
        FOP_WRITE  = 2'd1,
        FOP_PERASE = 2'd2,
        FOP_BULK   = 2'd3
    } fop_e;
endpackage

// File: rtl/fg_window.sv
// Boot window tracker: counts valid processor cycles after reset and
// reports whether the count is still below CYCLES. Assumes CYCLES >= 1.
module fg_window #(
    parameter int CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    output logic win
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    // Saturating count of strobed cycles since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cyc_en && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    // Window stays open until the limit is reached.
    always_comb win = (cnt != LIMIT);
endmodule

// File: rtl/fg_ctrl_regs.sv
// Control registers: a set-only lock bit accepted only inside the boot
// window, and a freely writable debug clock disable bit.
// Assumes single-cycle write strobes on a byte-wide port.
module fg_ctrl_regs #(
    parameter int          AW          = 8,
    parameter int          DW          = 8,
    parameter logic [7:0]  SEC_ADDR    = 8'hB2,
    parameter int          LOCK_BIT    = 6,
    parameter logic [7:0]  DBGCTL_ADDR = 8'hC4,
    parameter int          DIS_BIT     = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          lock,
    output logic          clk_dis
);
    logic sec_hit, ctl_hit;
    logic data_unused;

    // Address decode for the two registers.
    always_comb begin
        sec_hit     = wr_en && (wr_addr == AW'(SEC_ADDR));
        ctl_hit     = wr_en && (wr_addr == AW'(DBGCTL_ADDR));
        data_unused = ^wr_data;
    end

    // Lock only sets, only in the window; reset is the sole clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (sec_hit && win && wr_data[LOCK_BIT])
            lock <= 1'b1;
    end

    // Debug clock disable follows the written bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            clk_dis <= 1'b0;
        else if (ctl_hit)
            clk_dis <= wr_data[DIS_BIT];
    end
endmodule

// File: rtl/fg_policy.sv
// Access policy for one requester. IS_DBG selects the debug port rules
// (window and clock-disable shut-out, bulk erase only when locked).
// Purely combinational; assumes page 0 holds the boot code.
module fg_policy
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter bit IS_DBG = 1'b0
) (
    input  logic              lock,
    input  logic              win,
    input  logic              clk_dis,
    input  logic [1:0]        op,
    input  logic [PAGE_W-1:0] page,
    output logic              ok
);
    fop_e fop;
    logic blk;

    // Collect every reason this request must be blocked.
    always_comb begin
        fop = fop_e'(op);
        blk = 1'b0;
        if (IS_DBG && (win || clk_dis))
            blk = 1'b1;
        if (lock) begin
            if (IS_DBG && fop != FOP_BULK)
                blk = 1'b1;
            if (page == '0 && (fop == FOP_WRITE || fop == FOP_PERASE))
                blk = 1'b1;
        end
        ok = !blk;
    end
endmodule

// File: rtl/flash_guard.sv
// Top of the flash security controller: window tracker, control
// registers, one policy per requester and a processor-first merge onto
// a single flash command port. Assumes one flash command per cycle.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int CYCLES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [PAGE_W-1:0] cpu_page,
    input  logic              dbg_req,
    input  logic [1:0]        dbg_op,
    input  logic [PAGE_W-1:0] dbg_page,
    output logic              cpu_grant,
    output logic              cpu_reject,
    output logic              dbg_grant,
    output logic              dbg_reject,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [PAGE_W-1:0] fl_page,
    output logic              fl_src,
    output logic              pram_clr,
    output logic [7:0]        sts_sec,
    output logic              dbg_clk_en
);
    logic win, lock, clk_dis;
    logic [1:0] req_ok;
    logic [1:0]        src_op   [2];
    logic [PAGE_W-1:0] src_page [2];

    fg_window #(.CYCLES(CYCLES)) u_window (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .win(win)
    );

    fg_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .win(win),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .lock(lock), .clk_dis(clk_dis)
    );

    // Index 0 is the processor, index 1 the debug port.
    always_comb begin
        src_op[0]   = cpu_op;
        src_op[1]   = dbg_op;
        src_page[0] = cpu_page;
        src_page[1] = dbg_page;
    end

    for (genvar s = 0; s < 2; s++) begin : g_pol
        fg_policy #(.PAGE_W(PAGE_W), .IS_DBG(s == 1)) u_pol (
            .lock(lock), .win(win), .clk_dis(clk_dis),
            .op(src_op[s]), .page(src_page[s]), .ok(req_ok[s])
        );
    end

    // Grant, reject and processor-first merge onto the flash port.
    always_comb begin
        cpu_grant  = cpu_req && req_ok[0];
        cpu_reject = cpu_req && !req_ok[0];
        dbg_grant  = dbg_req && req_ok[1] && !cpu_grant;
        dbg_reject = dbg_req && !dbg_grant;
        fl_req     = cpu_grant || dbg_grant;
        fl_src     = dbg_grant;
        fl_op      = dbg_grant ? dbg_op : (cpu_grant ? cpu_op : 2'd0);
        fl_page    = dbg_grant ? dbg_page : (cpu_grant ? cpu_page : '0);
        pram_clr   = fl_req && (fop_e'(fl_op) == FOP_BULK);
    end

    // Status and debug clock outputs.
    always_comb begin
        sts_sec    = {win, lock, 6'b0};
        dbg_clk_en = !clk_dis;
    end
endmodule

// File: rtl/flash_guard_chk.sv
// Property checker for flash_guard, attached by bind.
module flash_guard_chk
    import flash_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_grant,
    input logic       cpu_reject,
    input logic       dbg_grant,
    input logic       dbg_reject,
    input logic [1:0] dbg_op,
    input logic       pram_clr,
    input logic [7:0] sts_sec,
    input logic       dbg_clk_en
);
    // R1: once closed, the window stays closed until reset.
    a_r1_window_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_sec[7] |=> !sts_sec[7]);
    // R1: no debug grant inside the window.
    a_r1_no_dbg_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        sts_sec[7] |-> !dbg_grant);
    // R4: lock is sticky.
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sts_sec[6] |=> sts_sec[6]);
    // R5: lock cannot rise after the window.
    a_r5_no_late_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_sec[6] && !sts_sec[7]) |=> !sts_sec[6]);
    // R6: a locked debug grant is a bulk erase.
    a_r6_dbg_bulk_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_sec[6] && dbg_grant) |-> (dbg_op == 2'd3));
    // R9: RAM clear only accompanies a forwarded command.
    a_r9_clr_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        pram_clr |-> (cpu_grant || dbg_grant));
    // R10: debug clock off means no debug grant.
    a_r10_clk_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_clk_en |-> !dbg_grant);
    // R11: grant and reject never together.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_grant && cpu_reject) && !(dbg_grant && dbg_reject));
endmodule

bind flash_guard flash_guard_chk u_chk (.*);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = '0;
    logic [7:0] cpu_page = '0;
    logic       dbg_req = 1'b0;
    logic [1:0] dbg_op = '0;
    logic [7:0] dbg_page = '0;
    logic       cpu_grant, cpu_reject, dbg_grant, dbg_reject;
    logic       fl_req, fl_src, pram_clr, dbg_clk_en;
    logic [1:0] fl_op;
    logic [7:0] fl_page;
    logic [7:0] sts_sec;

    int n_run = 0;
    int n_fail = 0;

    flash_guard u_flash_guard (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // One clock with optional strobe and optional register write.
    task automatic tick(input logic c, input logic w, input logic [7:0] a, input logic [7:0] d);
        cyc_en = c; reg_wr_en = w; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk);
        #1 cyc_en = 1'b0; reg_wr_en = 1'b0;
    endtask

    // Present one request between edges and check the answer.
    task automatic req(input string tag, input logic dbg, input logic [1:0] op,
                       input logic [7:0] pg, input logic exp_ok);
        if (dbg) begin dbg_req = 1; dbg_op = op; dbg_page = pg; end
        else     begin cpu_req = 1; cpu_op = op; cpu_page = pg; end
        #1;
        check({tag, " grant"}, dbg ? dbg_grant : cpu_grant, exp_ok);
        check({tag, " reject"}, dbg ? dbg_reject : cpu_reject, !exp_ok);
        check({tag, " fl_req"}, fl_req, exp_ok);
        if (exp_ok) begin
            check({tag, " R11 fl_op"}, fl_op, op);
            check({tag, " R11 fl_page"}, fl_page, pg);
            check({tag, " R11 fl_src"}, fl_src, dbg);
            check({tag, " R9 pram_clr"}, pram_clr, op == 2'd3);
        end
        cpu_req = 0; dbg_req = 0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 sts after reset", sts_sec, 8'h80);
        check("R2 dbg_clk_en after reset", dbg_clk_en, 1'b1);
    endtask

    task automatic t_window_lock();
        do_reset();
        req("R1 dbg read in window", 1, 2'd0, 8'd3, 0);
        req("R1 dbg bulk in window", 1, 2'd3, 8'd0, 0);
        req("R8 cpu write pg0 unlocked", 0, 2'd1, 8'd0, 1);
        tick(1, 1, 8'hB2, 8'h00);
        check("R3 zero write no effect", sts_sec, 8'h80);
        for (int i = 0; i < 30; i++) tick(1, 0, 8'h00, 8'h00);
        check("R1 open after 31 strobes", sts_sec[7], 1'b1);
        tick(1, 1, 8'hB2, 8'h40);
        check("R3 R1 set on 32nd strobe, window closed", sts_sec, 8'h40);
    endtask

    task automatic t_locked_rules();
        req("R6 dbg read locked", 1, 2'd0, 8'd3, 0);
        req("R6 dbg write locked", 1, 2'd1, 8'd3, 0);
        req("R6 dbg page erase locked", 1, 2'd2, 8'd3, 0);
        req("R6 dbg bulk locked", 1, 2'd3, 8'd0, 1);
        req("R7 dbg page erase pg0", 1, 2'd2, 8'd0, 0);
        req("R7 cpu page erase pg0", 0, 2'd2, 8'd0, 0);
        req("R7 cpu page erase pg5", 0, 2'd2, 8'd5, 1);
        req("R8 cpu write pg0", 0, 2'd1, 8'd0, 0);
        req("R8 cpu write pg2", 0, 2'd1, 8'd2, 1);
        req("R8 cpu read pg0", 0, 2'd0, 8'd0, 1);
        req("R9 cpu bulk locked", 0, 2'd3, 8'd0, 1);
        tick(1, 1, 8'hB2, 8'h00);
        check("R4 zero write keeps lock", sts_sec[6], 1'b1);
        do_reset();
        check("R4 reset clears lock", sts_sec, 8'h80);
    endtask

    task automatic t_late_set();
        do_reset();
        for (int i = 0; i < 32; i++) tick(1, 0, 8'h00, 8'h00);
        check("R1 closed after 32 strobes", sts_sec[7], 1'b0);
        tick(0, 1, 8'hB2, 8'hFF);
        check("R5 late set ignored", sts_sec, 8'h00);
        req("R5 dbg page erase pg0 unlocked", 1, 2'd2, 8'd0, 1);
        req("R9 dbg bulk unlocked", 1, 2'd3, 8'd0, 1);
    endtask

    task automatic t_clk_dis();
        tick(0, 1, 8'hC4, 8'h01);
        check("R10 clock enable off", dbg_clk_en, 1'b0);
        req("R10 dbg bulk with clock off", 1, 2'd3, 8'd0, 0);
        tick(0, 1, 8'hC4, 8'h00);
        check("R10 clock enable back", dbg_clk_en, 1'b1);
        req("R10 dbg read with clock on", 1, 2'd0, 8'd9, 1);
    endtask

    task automatic t_collide();
        cpu_req = 1; cpu_op = 2'd1; cpu_page = 8'd1;
        dbg_req = 1; dbg_op = 2'd0; dbg_page = 8'd7;
        #1;
        check("R12 cpu granted", cpu_grant, 1'b1);
        check("R12 dbg rejected", dbg_reject, 1'b1);
        check("R12 fl_src cpu", fl_src, 1'b0);
        check("R11 fl_page from cpu", fl_page, 8'd1);
        cpu_req = 0; dbg_req = 0;
        #1;
        check("R11 idle no fl_req", fl_req, 1'b0);
    endtask

    initial begin
        t_reset();
        t_window_lock();
        t_locked_rules();
        t_late_set();
        t_clk_dis();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule